// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block computes a cyclic redundancy check one bit per clock over a 32-bit shift register. A select code picks a polynomial from a small built-in table. Each entry in the table also sets the preset pattern in groups of four bits, whether the appended check word is inverted, and whether the entry is a normal polynomial, a stored residue constant, or a disabled slot that takes the register out of the feedback path.

To generate a check word, the user presets or clears the register and holds the gate input HIGH while data is shifted in. The data appears unchanged at the serial output. The user then drops the gate and clocks once for each bit of the polynomial order, and the check word leaves MSB first. After that the output stays at zero.

To check a frame, the user presets the register and shifts the data and its check word in with the gate HIGH. The status output is HIGH when the active part of the register is zero. The 32-bit Ethernet polynomial leaves a fixed non-zero remainder after a good frame. Selecting the residue entry for one extra clock removes that remainder, so a good frame still ends with the status HIGH.

Top module: `sercrc_unit`

## Requirements
- R1: Select codes: 0 selects a 16-bit polynomial 0x8005, 1 selects a 16-bit polynomial 0x1021, 2 selects the 32-bit polynomial 0x04C11DB7, 3 selects the residue entry with constant 0xC704DD7B, and 4 through 7 select the disabled entry. The active width is the order of the polynomial, and bit 0 is the LSB of the register.
- R2: In a polynomial mode with the gate HIGH, the serial output equals the serial input in the same cycle. On each clock the register shifts left by one over the active width. The bit (register MSB XOR serial input) is XORed into the polynomial tap positions.
- R3: In a polynomial mode with the gate LOW, the output shows the check word MSB first, one bit per clock, for n clocks, where n is the order. The bits are inverted only for code 2. Zeros shift into the register, and the serial input has no effect.
- R4: Once n clocks have passed with the gate LOW, the output is 0 until the gate goes HIGH again.
- R5: An asynchronous preset loads the register in groups of 4 bits as the entry dictates. Code 2 sets all 32 bits. Code 1 sets the low 16 bits. Every other code clears the register. The preset holds its value over any clock edge while it is asserted.
- R6: The asynchronous master reset clears the register and takes priority over both the preset and the clock.
- R7: The status output `ok_o` is HIGH exactly when the active-width register is zero. For codes 0 and 1, a frame followed by its check word gives HIGH. A frame with a corrupted bit gives LOW.
- R8: For code 2, a good frame followed by its inverted check word leaves 0xC704DD7B in the register, so `ok_o` is LOW. One clock with code 3 XORs that constant into the register, which leaves it at zero.
- R9: Under the disabled codes the register holds its value, the output equals the serial input, and `ok_o` is HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge |
| mrst_i | input | 1 | Asynchronous master reset, active HIGH, clears the register |
| pre_i | input | 1 | Asynchronous preset, active HIGH, loads the entry's preset pattern |
| sel_i | input | 3 | Table select code |
| sdat_i | input | 1 | Serial data input |
| gate_i | input | 1 | Check-word gate: HIGH passes data, LOW shifts out the check word |
| sdat_o | output | 1 | Serial data or check-word output |
| ok_o | output | 1 | HIGH when the active register bits are all zero |

## Verification
The assertions check several behaviours on every clock:
- data passes through while the gate is HIGH;
- the register shifts in zeros while the gate is LOW;
- the output is zero once the shift-out count is used up;
- the residue entry XORs its constant into the register;
- the disabled entry holds the register.

Only the bench's scenarios can show that the check words are correct for each polynomial and that the fixed Ethernet remainder appears. The same holds for the nibble-group preset patterns, the priority of master reset over preset, and a corrupted frame turning the status LOW.

// File: rtl/sercrc_pkg.sv
package sercrc_pkg;

    localparam int unsigned CRC_MAX_W = 32;
    localparam int unsigned ORD_W     = $clog2(CRC_MAX_W + 1);
    localparam int unsigned GRP_N     = CRC_MAX_W / 4;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_POLY = 2'd1,
        MODE_RES  = 2'd2
    } crc_mode_e;

    typedef struct packed {
        crc_mode_e              mode;
        logic [CRC_MAX_W-1:0]   poly;     // taps, or stored constant in MODE_RES
        logic [ORD_W-1:0]       order;
        logic [GRP_N-1:0]       set_grp;  // one bit per nibble: 1 = preset sets
        logic                   inv;
    } crc_entry_t;

    function automatic logic [CRC_MAX_W-1:0] ord_mask(input logic [ORD_W-1:0] n);
        logic [CRC_MAX_W-1:0] m;
        m = '0;
        for (int i = 0; i < CRC_MAX_W; i++) begin
            if (i < int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic top_bit(input logic [CRC_MAX_W-1:0] r,
                                     input logic [ORD_W-1:0] n);
        logic b;
        b = 1'b0;
        for (int i = 0; i < CRC_MAX_W; i++) begin
            if (i == int'(n) - 1) b = r[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/sercrc_table.sv
module sercrc_table
    import sercrc_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel_i,
    output crc_entry_t       ent_o
);

    always_comb begin
        ent_o = '{mode: MODE_OFF, poly: '0, order: '0, set_grp: '0, inv: 1'b0};
        case (sel_i)
            SEL_W'(0): ent_o = '{mode: MODE_POLY, poly: 32'h0000_8005,
                                 order: ORD_W'(16), set_grp: '0, inv: 1'b0};
            SEL_W'(1): ent_o = '{mode: MODE_POLY, poly: 32'h0000_1021,
                                 order: ORD_W'(16), set_grp: GRP_N'(8'h0F), inv: 1'b0};
            SEL_W'(2): ent_o = '{mode: MODE_POLY, poly: 32'h04C1_1DB7,
                                 order: ORD_W'(32), set_grp: '1, inv: 1'b1};
            SEL_W'(3): ent_o = '{mode: MODE_RES, poly: 32'hC704_DD7B,
                                 order: ORD_W'(32), set_grp: '0, inv: 1'b0};
            default:   ent_o = '{mode: MODE_OFF, poly: '0, order: '0,
                                 set_grp: '0, inv: 1'b0};
        endcase
    end

endmodule

// File: rtl/sercrc_cwcnt.sv
module sercrc_cwcnt #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             mrst_i,
    input  logic             pre_i,
    input  logic             run_i,
    input  logic             gate_i,
    input  logic [CNT_W-1:0] order_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        done_o = (cnt_q >= order_i);
        cnt_d  = cnt_q;
        if (run_i) begin
            if (gate_i)       cnt_d = '0;
            else if (!done_o) cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge mrst_i or posedge pre_i) begin
        if (mrst_i)     cnt_q <= '0;
        else if (pre_i) cnt_q <= '0;
        else            cnt_q <= cnt_d;
    end

    // R4
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (mrst_i || pre_i)
        (run_i && !gate_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/sercrc_next.sv
module sercrc_next
    import sercrc_pkg::*;
#(
    parameter int unsigned REG_W = CRC_MAX_W
) (
    input  crc_entry_t       ent_i,
    input  logic [REG_W-1:0] crc_i,
    input  logic [REG_W-1:0] mask_i,
    input  logic             msb_i,
    input  logic             sdat_i,
    input  logic             gate_i,
    input  logic             done_i,
    output logic [REG_W-1:0] crc_o,
    output logic             sdat_o
);

    logic fb;

    always_comb begin
        fb     = 1'b0;
        crc_o  = crc_i;
        sdat_o = sdat_i;
        case (ent_i.mode)
            MODE_POLY: begin
                if (gate_i) begin
                    fb    = msb_i ^ sdat_i;
                    crc_o = ((crc_i << 1) ^ (fb ? ent_i.poly[REG_W-1:0] : '0)) & mask_i;
                end else begin
                    crc_o  = (crc_i << 1) & mask_i;
                    sdat_o = done_i ? 1'b0 : (msb_i ^ ent_i.inv);
                end
            end
            MODE_RES: begin
                crc_o = crc_i ^ ent_i.poly[REG_W-1:0];
            end
            default: begin
                crc_o = crc_i;
            end
        endcase
    end

endmodule

// File: rtl/sercrc_unit.sv
module sercrc_unit
    import sercrc_pkg::*;
#(
    parameter int unsigned REG_W = CRC_MAX_W,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             mrst_i,
    input  logic             pre_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             sdat_i,
    input  logic             gate_i,
    output logic             sdat_o,
    output logic             ok_o
);

    localparam int unsigned CNT_W = ORD_W;
    localparam int unsigned NIB_N = REG_W / 4;

    typedef struct packed {
        logic [REG_W-1:0] crc;
    } state_t;

    state_t           st_d, st_q;
    crc_entry_t       ent;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] pre_vec;
    logic [REG_W-1:0] crc_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             done;
    logic             msb;
    logic             run;

    sercrc_table #(.SEL_W(SEL_W)) table_i (
        .sel_i (sel_i),
        .ent_o (ent)
    );

    assign run  = (ent.mode == MODE_POLY);
    assign mask = ord_mask(ent.order);
    assign msb  = top_bit(st_q.crc, ent.order);

    for (genvar g = 0; g < NIB_N; g++) begin : g_pre
        assign pre_vec[4*g +: 4] = {4{ent.set_grp[g]}} & mask[4*g +: 4];
    end

    sercrc_cwcnt #(.CNT_W(CNT_W)) cnt_i (
        .clk_i   (clk_i),
        .mrst_i  (mrst_i),
        .pre_i   (pre_i),
        .run_i   (run),
        .gate_i  (gate_i),
        .order_i (ent.order),
        .cnt_q   (cnt_q),
        .done_o  (done)
    );

    sercrc_next #(.REG_W(REG_W)) next_i (
        .ent_i  (ent),
        .crc_i  (st_q.crc),
        .mask_i (mask),
        .msb_i  (msb),
        .sdat_i (sdat_i),
        .gate_i (gate_i),
        .done_i (done),
        .crc_o  (crc_nx),
        .sdat_o (sdat_o)
    );

    always_comb begin
        st_d.crc = crc_nx;
        ok_o     = ((st_q.crc & mask) == '0);
    end

    always_ff @(posedge clk_i or posedge mrst_i or posedge pre_i) begin
        if (mrst_i)     st_q.crc <= '0;
        else if (pre_i) st_q.crc <= pre_vec;
        else            st_q     <= st_d;
    end

    // R2
    pass_thru_chk: assert property (@(posedge clk_i) disable iff (mrst_i || pre_i)
        (run && gate_i) |-> (sdat_o == sdat_i));

    // R3
    zero_fill_chk: assert property (@(posedge clk_i) disable iff (mrst_i || pre_i)
        (run && !gate_i) |=> (st_q.crc == (($past(st_q.crc) << 1) & $past(mask))));

    // R4
    quiet_tail_chk: assert property (@(posedge clk_i) disable iff (mrst_i || pre_i)
        (run && !gate_i && (cnt_q >= ent.order)) |-> !sdat_o);

    // R8
    res_apply_chk: assert property (@(posedge clk_i) disable iff (mrst_i || pre_i)
        (ent.mode == MODE_RES) |=> (st_q.crc == ($past(st_q.crc) ^ 32'hC704_DD7B)));

    // R9
    off_hold_chk: assert property (@(posedge clk_i) disable iff (mrst_i || pre_i)
        (ent.mode == MODE_OFF) |=> $stable(st_q.crc));

    // R9
    off_ok_chk: assert property (@(posedge clk_i) disable iff (mrst_i || pre_i)
        (ent.mode == MODE_OFF) |-> (ok_o && (sdat_o == sdat_i)));

endmodule

// File: tb/sercrc_unit_tb.sv
module sercrc_unit_tb_top;

    logic       clk_i = 1'b0;
    logic       mrst_i = 1'b1;
    logic       pre_i = 1'b0;
    logic [2:0] sel_i = 3'd0;
    logic       sdat_i = 1'b0;
    logic       gate_i = 1'b1;
    logic       sdat_o;
    logic       ok_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk_i = ~clk_i;

    sercrc_unit dut_i (
        .clk_i  (clk_i),
        .mrst_i (mrst_i),
        .pre_i  (pre_i),
        .sel_i  (sel_i),
        .sdat_i (sdat_i),
        .gate_i (gate_i),
        .sdat_o (sdat_o),
        .ok_o   (ok_o)
    );

    function automatic logic [31:0] m_poly(input int c);
        case (c)
            0: return 32'h0000_8005;
            1: return 32'h0000_1021;
            2: return 32'h04C1_1DB7;
            default: return 32'h0;
        endcase
    endfunction

    function automatic int m_ord(input int c);
        return (c == 2) ? 32 : 16;
    endfunction

    function automatic logic [31:0] m_pre(input int c);
        case (c)
            1: return 32'h0000_FFFF;
            2: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_step(input logic [31:0] r, input logic b,
                                           input int c);
        logic [31:0] m;
        logic        fb;
        int          n;
        n  = m_ord(c);
        m  = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        fb = r[n-1] ^ b;
        r  = (r << 1) & m;
        if (fb) r = r ^ (m_poly(c) & m);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic d, input logic g, output logic o);
        sdat_i = d;
        gate_i = g;
        #1;
        o = sdat_o;
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic rd_ok(output logic k);
        #1;
        k = ok_o;
    endtask

    task automatic do_pre(input logic [2:0] c);
        sel_i = c;
        pre_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        pre_i = 1'b0;
    endtask

    // shift out n bits with gate LOW, returns collected word MSB first
    task automatic read_out(input int n, output logic [31:0] w);
        logic o;
        w = '0;
        for (int i = 0; i < n; i++) begin
            step(1'($urandom % 2), 1'b0, o);
            w[n-1-i] = o;
        end
    endtask

    task automatic run_frame(input int c, input int nb, input bit corrupt);
        logic [63:0] d;
        logic [31:0] r, cw;
        logic        o, k, b, inv;
        int          n, fi;
        n   = m_ord(c);
        inv = (c == 2);
        d   = {$urandom(), $urandom()};
        do_pre(3'(c));
        r = m_pre(c);
        for (int i = 0; i < nb; i++) begin
            step(d[i], 1'b1, o);
            chk("R2 pass-through", 32'(o), 32'(d[i]));
            r = m_step(r, d[i], c);
        end
        cw = '0;
        for (int i = 0; i < n; i++) begin
            step(1'($urandom % 2), 1'b0, o);
            chk("R3 check word bit", 32'(o), 32'(r[n-1-i] ^ inv));
            cw[n-1-i] = o;
        end
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, o);
            chk("R4 zero tail", 32'(o), 32'd0);
        end
        do_pre(3'(c));
        fi = $urandom % (nb + n);
        for (int i = 0; i < nb + n; i++) begin
            b = (i < nb) ? d[i] : cw[n-1-(i-nb)];
            if (corrupt && i == fi) b = ~b;
            step(b, 1'b1, o);
        end
        rd_ok(k);
        if (c != 2) begin
            chk("R7 frame status", 32'(k), 32'(!corrupt));
        end else begin
            if (!corrupt) chk("R8 residue non-zero", 32'(k), 32'd0);
            sel_i = 3'd3;
            step(1'b0, 1'b0, o);
            rd_ok(k);
            chk("R8 residue cleared", 32'(k), 32'(!corrupt));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic        o, k;
        logic [31:0] w, r, cw;
        logic [63:0] d;
        void'($urandom(32'd20240611));

        @(posedge clk_i);
        @(negedge clk_i);
        mrst_i = 1'b0;
        rd_ok(k);
        chk("R6 reset state ok", 32'(k), 32'd1);

        // R5 preset patterns by nibble group
        do_pre(3'd1);
        rd_ok(k);
        chk("R5 ccitt preset ok", 32'(k), 32'd0);
        read_out(16, w);
        chk("R5 ccitt preset value", w, 32'h0000_FFFF);
        do_pre(3'd0);
        read_out(16, w);
        chk("R5 crc16 clear value", w, 32'h0);
        do_pre(3'd2);
        rd_ok(k);
        chk("R5 eth preset ok", 32'(k), 32'd0);
        read_out(32, w);
        chk("R5 eth preset value inverted", w, 32'h0);

        // R6 master reset beats preset; preset beats clock
        sel_i = 3'd1;
        sdat_i = 1'b1;
        gate_i = 1'b1;
        pre_i  = 1'b1;
        @(posedge clk_i);
        @(posedge clk_i);
        @(negedge clk_i);
        pre_i = 1'b0;
        read_out(16, w);
        chk("R5 preset held over clocks", w, 32'h0000_FFFF);
        do_pre(3'd2);
        mrst_i = 1'b1;
        pre_i  = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        mrst_i = 1'b0;
        pre_i  = 1'b0;
        rd_ok(k);
        chk("R6 reset over preset", 32'(k), 32'd1);

        // R1 R2 R3 R4 R7 R8 random frames over each code
        for (int t = 0; t < 6; t++) begin
            run_frame(0, 8 + ($urandom % 50), 1'b0);
            run_frame(1, 8 + ($urandom % 50), 1'b0);
            run_frame(2, 8 + ($urandom % 50), 1'b0);
        end
        for (int t = 0; t < 4; t++) begin
            run_frame(0, 20 + ($urandom % 40), 1'b1);
            run_frame(1, 20 + ($urandom % 40), 1'b1);
            run_frame(2, 20 + ($urandom % 40), 1'b1);
        end

        // R8 read the Ethernet remainder through the serial output
        d = {$urandom(), $urandom()};
        do_pre(3'd2);
        r = m_pre(2);
        for (int i = 0; i < 40; i++) begin
            step(d[i], 1'b1, o);
            r = m_step(r, d[i], 2);
        end
        cw = ~r;
        for (int i = 0; i < 32; i++) step(cw[31-i], 1'b1, o);
        read_out(32, w);
        chk("R8 residue value", ~w, 32'hC704_DD7B);

        // R9 disabled codes hold the register and pass data
        do_pre(3'd0);
        r = 32'h0;
        for (int i = 0; i < 12; i++) begin
            step(1'(i % 3 == 0), 1'b1, o);
            r = m_step(r, 1'(i % 3 == 0), 0);
        end
        for (int c = 4; c < 8; c++) begin
            sel_i = 3'(c);
            for (int i = 0; i < 4; i++) begin
                logic b;
                b = 1'($urandom % 2);
                step(b, 1'($urandom % 2), o);
                chk("R9 disabled pass-through", 32'(o), 32'(b));
            end
            rd_ok(k);
            chk("R9 disabled ok", 32'(k), 32'd1);
        end
        sel_i = 3'd0;
        read_out(16, w);
        chk("R9 register held", w, r);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule